// File: doc/BRIEF.md
# Static Memory Strobe Timing Engine

This block runs one chip-select of an external asynchronous static memory bus. A request port hands it an address, a read/write flag, write data and byte enables. From these it generates an active-low chip-select, read strobe and write strobe, plus per-lane byte selects and an output enable for the shared data bus. Every strobe is placed inside the access by its own setup count (cycles from address valid to assertion) and pulse count, both in clock cycles. The access length comes from a programmable total cycle count, stretched when needed to honour a minimum recovery time after each strobe.

Read data is captured at the release of either the chip-select or the read strobe, whichever the sampling mode selects. Write data is put on the bus from the first cycle of either the chip-select or the write strobe, as the drive mode selects. An external wait input can be ignored, can freeze the whole access, or can hold only the release of the data strobe. After a read, a programmable float time keeps the bus free before the next access. An optional shortcut skips that time when the next access is also a read. Timing and mode inputs are sampled when an access is accepted. A one-cycle done pulse closes each access and carries the captured read data.

Top module: `smemStrobeEngine`

## Requirements
- R1: After reset memCsN, memRdN, every memWeN and every memBsN bit are 1, memDoe and doneValid are 0, and reqReady is 1.
- R2: An access is accepted on a clock edge with reqValid and reqReady both 1. The following cycle is access cycle 0. Each strobe is low exactly in access counts c with setup <= c < setup+pulse, so setup 0 asserts in cycle 0 and pulse 0 never asserts. The chip-select uses the read-side values for reads and the write-side values for writes. memRdN is low only on reads, and the write strobe is low only on writes.
- R3: An access lasts max(cycle, csSetup+csPulse+csRecover, dataSetup+dataPulse+dataRecover, 1) counts. doneValid is 1 for exactly one cycle, the cycle after the last count.
- R4: All timing and mode inputs are taken on the accept edge. Changing them during an access does not alter that access.
- R5: With rdSampleMode 0, memDin is captured in the last count of the chip-select pulse. With rdSampleMode 1, it is captured in the last count of the read strobe pulse. rdData shows the capture while doneValid is 1. If the selected strobe has pulse 0, rdData keeps its previous value.
- R6: On writes, memDoe rises in the first count of the chip-select (wrDriveMode 0) or of the write strobe (wrDriveMode 1) and stays 1 to the end of the access. It is 0 on reads and whenever the chosen strobe has pulse 0. memDout equals the accepted write data.
- R7: With laneMode 0 (byte select), memBsN[i] is the inverse of byte enable i for the whole access and all memWeN bits follow the common write strobe. With laneMode 1 (byte write), memBsN stays all 1 and memWeN[i] is low only while the write strobe is active and byte enable i is 1.
- R8: With waitMode 2, the access counter does not advance in any cycle where memWait is 1, and all strobes hold their state.
- R9: With waitMode 3, the counter holds only in the last count of the data strobe pulse while memWait is 1, which delays that strobe's release.
- R10: With waitMode 0 or 1, memWait has no effect on strobes or length.
- R11: After a read with floatOpt 0, reqReady is 0 in the done cycle and the next floatCycles cycles, floatCycles+1 cycles in all. After a write, there is no such delay.
- R12: After a read with floatOpt 1, a following read sees no float delay, while a following write still waits floatCycles+1 cycles.
- R13: memAddr holds the accepted address for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | 8*BUS_BYTES | Write data |
| reqBe | input | BUS_BYTES | Byte enables |
| reqReady | output | 1 | Request may be accepted |
| doneValid | output | 1 | One-cycle end-of-access pulse |
| rdData | output | 8*BUS_BYTES | Captured read data |
| csRdSetup | input | 8 | Chip-select setup, reads |
| rdSetup | input | 8 | Read strobe setup |
| csWrSetup | input | 8 | Chip-select setup, writes |
| wrSetup | input | 8 | Write strobe setup |
| csRdPulse | input | 8 | Chip-select pulse, reads |
| rdPulse | input | 8 | Read strobe pulse |
| csWrPulse | input | 8 | Chip-select pulse, writes |
| wrPulse | input | 8 | Write strobe pulse |
| rdCycle | input | 8 | Read cycle length |
| wrCycle | input | 8 | Write cycle length |
| csRdRecover | input | 8 | Chip-select recovery, reads |
| rdRecover | input | 8 | Read strobe recovery |
| csWrRecover | input | 8 | Chip-select recovery, writes |
| wrRecover | input | 8 | Write strobe recovery |
| rdSampleMode | input | 1 | 0 capture at chip-select release, 1 at read strobe release |
| wrDriveMode | input | 1 | 0 drive from chip-select, 1 from write strobe |
| laneMode | input | 1 | 0 byte select, 1 byte write |
| waitMode | input | 2 | 0/1 off, 2 freeze, 3 hold release |
| floatCycles | input | 4 | Float time after a read, minus one |
| floatOpt | input | 1 | Skip float time for read after read |
| memWait | input | 1 | External wait, active high |
| memDin | input | 8*BUS_BYTES | Data from memory |
| memAddr | output | ADDR_W | Address to memory |
| memCsN | output | 1 | Chip-select, active low |
| memRdN | output | 1 | Read strobe, active low |
| memWeN | output | BUS_BYTES | Write strobes, active low |
| memBsN | output | BUS_BYTES | Byte selects, active low |
| memDout | output | 8*BUS_BYTES | Data to memory |
| memDoe | output | 1 | Data output enable |

## Verification
The assertions assume that memWait is already synchronous to clk and that, in freeze mode, it does not stay high forever. The hold check also assumes no new request arrives while the controller is busy. The stimulus sets memWait at the falling edge from a random bit per cycle, so it goes low within a few cycles in every mode. It raises reqValid only through the accept handshake and drops it right after the accept edge. Random setup, pulse and recovery values are kept small, so the access count stays far below the counter range.

// File: rtl/smemPkg.sv
package smemPkg;
  typedef enum logic {S_IDLE, S_ACC} accState_e;

  typedef struct packed {
    logic load;
    logic active;
    logic csOn;
    logic rdOn;
    logic weOn;
    logic capture;
    logic driveOn;
    logic byteWrite;
  } strobeBus_t;
endpackage

// File: rtl/smemCtrl.sv
module smemCtrl
  import smemPkg::*;
#(
  parameter int TW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  output logic          reqReady,
  output logic          doneValid,
  input  logic [TW-1:0] csRdSetup,
  input  logic [TW-1:0] rdSetup,
  input  logic [TW-1:0] csWrSetup,
  input  logic [TW-1:0] wrSetup,
  input  logic [TW-1:0] csRdPulse,
  input  logic [TW-1:0] rdPulse,
  input  logic [TW-1:0] csWrPulse,
  input  logic [TW-1:0] wrPulse,
  input  logic [TW-1:0] rdCycle,
  input  logic [TW-1:0] wrCycle,
  input  logic [TW-1:0] csRdRecover,
  input  logic [TW-1:0] rdRecover,
  input  logic [TW-1:0] csWrRecover,
  input  logic [TW-1:0] wrRecover,
  input  logic          rdSampleMode,
  input  logic          wrDriveMode,
  input  logic          laneMode,
  input  logic [1:0]    waitMode,
  input  logic [FW-1:0] floatCycles,
  input  logic          floatOpt,
  input  logic          memWait,
  output strobeBus_t    strb
);
  localparam int CW  = TW + 2;
  localparam int FCW = FW + 1;

  function automatic logic [CW-1:0] span3(input logic [TW-1:0] a, b, c);
    return CW'(a) + CW'(b) + CW'(c);
  endfunction

  function automatic logic inWin(input logic [CW-1:0] c, input logic [TW-1:0] s, p);
    return (c >= CW'(s)) && (c < CW'(s) + CW'(p));
  endfunction

  accState_e      state;
  logic [CW-1:0]  cnt, effCyc, cntInc;
  logic [TW-1:0]  csSet, csPul, dSet, dPul;
  logic           isWrite, sampleOnData, driveOnData, byteWr, fOpt, driveSeen;
  logic [1:0]     wMode;
  logic [FW-1:0]  fCyc;
  logic [FCW-1:0] floatCnt;

  logic [CW-1:0]  csSpan, dSpan, cycIn, nextCyc;
  logic           accept, csNow, dNow, csLast, dLast, stall, advance, lastCyc;
  logic           captureNow, driveNow;

  always_comb begin
    csSpan  = reqWrite ? span3(csWrSetup, csWrPulse, csWrRecover)
                       : span3(csRdSetup, csRdPulse, csRdRecover);
    dSpan   = reqWrite ? span3(wrSetup, wrPulse, wrRecover)
                       : span3(rdSetup, rdPulse, rdRecover);
    cycIn   = CW'(reqWrite ? wrCycle : rdCycle);
    nextCyc = CW'(1);
    if (cycIn  > nextCyc) nextCyc = cycIn;
    if (csSpan > nextCyc) nextCyc = csSpan;
    if (dSpan  > nextCyc) nextCyc = dSpan;
  end

  assign reqReady = (state == S_IDLE) && ((floatCnt == '0) || (fOpt && !reqWrite));
  assign accept   = reqValid && reqReady;

  assign cntInc  = cnt + CW'(1);
  assign csNow   = (state == S_ACC) && inWin(cnt, csSet, csPul);
  assign dNow    = (state == S_ACC) && inWin(cnt, dSet, dPul);
  assign csLast  = csNow && (cntInc == CW'(csSet) + CW'(csPul));
  assign dLast   = dNow && (cntInc == CW'(dSet) + CW'(dPul));
  assign lastCyc = (cntInc == effCyc);

  always_comb begin
    unique case (wMode)
      2'd2:    stall = memWait;
      2'd3:    stall = memWait && dLast;
      default: stall = 1'b0;
    endcase
  end

  assign advance    = (state == S_ACC) && !stall;
  assign captureNow = !isWrite && advance && (sampleOnData ? dLast : csLast);
  assign driveNow   = isWrite && (state == S_ACC) &&
                      (driveSeen || (driveOnData ? dNow : csNow));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= S_IDLE;
      cnt          <= '0;
      effCyc       <= CW'(1);
      csSet        <= '0;
      csPul        <= '0;
      dSet         <= '0;
      dPul         <= '0;
      isWrite      <= 1'b0;
      sampleOnData <= 1'b0;
      driveOnData  <= 1'b0;
      byteWr       <= 1'b0;
      wMode        <= 2'd0;
      fCyc         <= '0;
      fOpt         <= 1'b0;
      floatCnt     <= '0;
      driveSeen    <= 1'b0;
      doneValid    <= 1'b0;
    end else begin
      doneValid <= 1'b0;
      if (floatCnt != '0) floatCnt <= floatCnt - FCW'(1);
      if (driveNow) driveSeen <= 1'b1;
      if (state == S_IDLE) begin
        if (accept) begin
          state        <= S_ACC;
          cnt          <= '0;
          effCyc       <= nextCyc;
          isWrite      <= reqWrite;
          csSet        <= reqWrite ? csWrSetup : csRdSetup;
          csPul        <= reqWrite ? csWrPulse : csRdPulse;
          dSet         <= reqWrite ? wrSetup   : rdSetup;
          dPul         <= reqWrite ? wrPulse   : rdPulse;
          sampleOnData <= rdSampleMode;
          driveOnData  <= wrDriveMode;
          byteWr       <= laneMode;
          wMode        <= waitMode;
          fCyc         <= floatCycles;
          fOpt         <= floatOpt;
          driveSeen    <= 1'b0;
        end
      end else if (advance) begin
        if (lastCyc) begin
          state     <= S_IDLE;
          doneValid <= 1'b1;
          if (!isWrite) floatCnt <= FCW'(fCyc) + FCW'(1);
        end else begin
          cnt <= cntInc;
        end
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.load      = accept;
    strb.active    = (state == S_ACC);
    strb.csOn      = csNow;
    strb.rdOn      = dNow && !isWrite;
    strb.weOn      = dNow && isWrite;
    strb.capture   = captureNow;
    strb.driveOn   = driveNow;
    strb.byteWrite = byteWr;
  end

  a_r3_single_done: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACC) |-> (cnt < effCyc));

  a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACC && wMode == 2'd2 && memWait) |=> ($stable(cnt) && state == S_ACC));

  a_r11_float_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !isWrite && !fOpt) |-> !reqReady);
endmodule

// File: rtl/smemData.sv
module smemData
  import smemPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NB     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeBus_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [8*NB-1:0]   reqWdata,
  input  logic [NB-1:0]     reqBe,
  input  logic [8*NB-1:0]   memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memRdN,
  output logic [NB-1:0]     memWeN,
  output logic [NB-1:0]     memBsN,
  output logic [8*NB-1:0]   memDout,
  output logic              memDoe,
  output logic [8*NB-1:0]   rdData
);
  logic [ADDR_W-1:0] addrQ;
  logic [8*NB-1:0]   wdataQ, rdQ;
  logic [NB-1:0]     beQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      rdQ    <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqBe;
      end
      if (strb.capture) rdQ <= memDin;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign memWeN[i] = strb.byteWrite ? !(strb.weOn && beQ[i]) : !strb.weOn;
    assign memBsN[i] = !(strb.active && !strb.byteWrite && beQ[i]);
  end

  assign memAddr = addrQ;
  assign memCsN  = !strb.csOn;
  assign memRdN  = !strb.rdOn;
  assign memDout = wdataQ;
  assign memDoe  = strb.driveOn;
  assign rdData  = rdQ;

  a_r2_rd_we_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !memRdN |-> (&memWeN));

  a_r6_doe_not_on_read: assert property (@(posedge clk) disable iff (!rstN)
    memDoe |-> memRdN);

  a_r13_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));
endmodule

// File: rtl/smemStrobeEngine.sv
module smemStrobeEngine
  import smemPkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BUS_BYTES = 4,
  parameter int TW        = 8,
  parameter int FW        = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [8*BUS_BYTES-1:0] reqWdata,
  input  logic [BUS_BYTES-1:0]   reqBe,
  output logic                   reqReady,
  output logic                   doneValid,
  output logic [8*BUS_BYTES-1:0] rdData,
  input  logic [TW-1:0]          csRdSetup,
  input  logic [TW-1:0]          rdSetup,
  input  logic [TW-1:0]          csWrSetup,
  input  logic [TW-1:0]          wrSetup,
  input  logic [TW-1:0]          csRdPulse,
  input  logic [TW-1:0]          rdPulse,
  input  logic [TW-1:0]          csWrPulse,
  input  logic [TW-1:0]          wrPulse,
  input  logic [TW-1:0]          rdCycle,
  input  logic [TW-1:0]          wrCycle,
  input  logic [TW-1:0]          csRdRecover,
  input  logic [TW-1:0]          rdRecover,
  input  logic [TW-1:0]          csWrRecover,
  input  logic [TW-1:0]          wrRecover,
  input  logic                   rdSampleMode,
  input  logic                   wrDriveMode,
  input  logic                   laneMode,
  input  logic [1:0]             waitMode,
  input  logic [FW-1:0]          floatCycles,
  input  logic                   floatOpt,
  input  logic                   memWait,
  input  logic [8*BUS_BYTES-1:0] memDin,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memCsN,
  output logic                   memRdN,
  output logic [BUS_BYTES-1:0]   memWeN,
  output logic [BUS_BYTES-1:0]   memBsN,
  output logic [8*BUS_BYTES-1:0] memDout,
  output logic                   memDoe
);
  strobeBus_t strb;

  smemCtrl #(.TW(TW), .FW(FW)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .doneValid(doneValid),
    .csRdSetup(csRdSetup), .rdSetup(rdSetup), .csWrSetup(csWrSetup), .wrSetup(wrSetup),
    .csRdPulse(csRdPulse), .rdPulse(rdPulse), .csWrPulse(csWrPulse), .wrPulse(wrPulse),
    .rdCycle(rdCycle), .wrCycle(wrCycle),
    .csRdRecover(csRdRecover), .rdRecover(rdRecover),
    .csWrRecover(csWrRecover), .wrRecover(wrRecover),
    .rdSampleMode(rdSampleMode), .wrDriveMode(wrDriveMode), .laneMode(laneMode),
    .waitMode(waitMode), .floatCycles(floatCycles), .floatOpt(floatOpt),
    .memWait(memWait), .strb(strb)
  );

  smemData #(.ADDR_W(ADDR_W), .NB(BUS_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqBe(reqBe), .memDin(memDin), .memAddr(memAddr), .memCsN(memCsN),
    .memRdN(memRdN), .memWeN(memWeN), .memBsN(memBsN), .memDout(memDout),
    .memDoe(memDoe), .rdData(rdData)
  );
endmodule

// File: tb/smemStrobeEngine_test.sv
module smemStrobeEngine_test;
  localparam int AW = 24;
  localparam int NB = 4;
  localparam int DW = 8 * NB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0, memDin = '0;
  logic [NB-1:0] reqBe = '0;
  logic [7:0]    tv [14];
  logic          rdMode = 1'b0, wrMode = 1'b0, bwMode = 1'b0, fOpt = 1'b0, memWait = 1'b0;
  logic [1:0]    wMode = 2'd0;
  logic [3:0]    fCycles = 4'd0;

  logic          reqReady, doneValid, memCsN, memRdN, memDoe;
  logic [DW-1:0] rdData, memDout;
  logic [AW-1:0] memAddr;
  logic [NB-1:0] memWeN, memBsN;

  smemStrobeEngine #(.ADDR_W(AW), .BUS_BYTES(NB)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .reqReady(reqReady),
    .doneValid(doneValid), .rdData(rdData),
    .csRdSetup(tv[0]), .rdSetup(tv[1]), .csWrSetup(tv[2]), .wrSetup(tv[3]),
    .csRdPulse(tv[4]), .rdPulse(tv[5]), .csWrPulse(tv[6]), .wrPulse(tv[7]),
    .rdCycle(tv[8]), .wrCycle(tv[9]),
    .csRdRecover(tv[10]), .rdRecover(tv[11]), .csWrRecover(tv[12]), .wrRecover(tv[13]),
    .rdSampleMode(rdMode), .wrDriveMode(wrMode), .laneMode(bwMode), .waitMode(wMode),
    .floatCycles(fCycles), .floatOpt(fOpt), .memWait(memWait), .memDin(memDin),
    .memAddr(memAddr), .memCsN(memCsN), .memRdN(memRdN), .memWeN(memWeN),
    .memBsN(memBsN), .memDout(memDout), .memDoe(memDoe)
  );

  int nChecks = 0, nFails = 0, accIdx = 0;
  logic [DW-1:0] prevRd = '0;
  bit prevRead = 0, prevOpt = 0;
  int prevF = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int w);
    return 32'hC3A50000 ^ DW'(accIdx << 8) ^ DW'(w);
  endfunction

  function automatic bit win(input int c, input int s, input int p);
    return (c >= s) && (c < s + p);
  endfunction

  task automatic randCfg();
    for (int i = 0; i < 8; i++) tv[i] = 8'($urandom_range(0, 6));
    tv[8]  = 8'($urandom_range(0, 20));
    tv[9]  = 8'($urandom_range(0, 20));
    for (int i = 10; i < 14; i++) tv[i] = 8'($urandom_range(0, 4));
    rdMode  = 1'($urandom_range(0, 1));
    wrMode  = 1'($urandom_range(0, 1));
    bwMode  = 1'($urandom_range(0, 1));
    wMode   = 2'($urandom_range(0, 3));
    fCycles = 4'($urandom_range(0, 15));
    fOpt    = 1'($urandom_range(0, 1));
  endtask

  task automatic runAccess(input bit wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input logic [NB-1:0] be);
    int sCs, pCs, rCs, sD, pD, rD, cyc, len, gap, expGap, c, w;
    bit rm, dm, bw, ended, seen, stall, wt, csA, dA, drv, expCs, expRd, expDoe;
    logic [1:0] wm;
    logic [NB-1:0] expWe, expBs;
    logic [DW-1:0] expData;
    int errCs, errRd, errWe, errBs, errDoe, errDone;
    string tagW;
    sCs = wr ? tv[2] : tv[0];  pCs = wr ? tv[6] : tv[4];  rCs = wr ? tv[12] : tv[10];
    sD  = wr ? tv[3] : tv[1];  pD  = wr ? tv[7] : tv[5];  rD  = wr ? tv[13] : tv[11];
    cyc = wr ? tv[9] : tv[8];
    rm = rdMode; dm = wrMode; bw = bwMode; wm = wMode;
    len = 1;
    if (cyc > len) len = cyc;
    if (sCs + pCs + rCs > len) len = sCs + pCs + rCs;
    if (sD + pD + rD > len) len = sD + pD + rD;
    accIdx++;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd; reqBe = be;
    #1;
    gap = 0;
    while (!reqReady && gap < 40) begin
      gap++;
      @(negedge clk);
    end
    expGap = (prevRead && (!prevOpt || wr)) ? prevF + 1 : 0;
    chk(gap == expGap, (prevRead && prevOpt) ? "R12 float gap" : "R11 float gap", 32'(gap), 32'(expGap));
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    randCfg();  // R4: scramble live timing inputs after the accept edge
    c = 0; w = 0; ended = 0; seen = 0;
    errCs = 0; errRd = 0; errWe = 0; errBs = 0; errDoe = 0; errDone = 0;
    expData = prevRd;
    forever begin
      @(negedge clk);
      if (ended || w > 400) break;
      if (doneValid) errDone++;
      if (w == 0) begin
        chk(memAddr == a, "R13 address", 32'(memAddr), 32'(a));
        chk(memDout == wd, "R6 write data", memDout, wd);
      end
      if (memAddr != a) errCs++;
      csA = win(c, sCs, pCs);
      dA  = win(c, sD, pD);
      expCs = !csA;
      expRd = !(dA && !wr);
      for (int i = 0; i < NB; i++) begin
        expWe[i] = bw ? !(dA && wr && be[i]) : !(dA && wr);
        expBs[i] = bw ? 1'b1 : !be[i];
      end
      drv = wr && (seen || (dm ? dA : csA));
      expDoe = drv;
      if (drv) seen = 1;
      if (memCsN != expCs) errCs++;
      if (memRdN != expRd) errRd++;
      if (memWeN != expWe) errWe++;
      if (memBsN != expBs) errBs++;
      if (memDoe != expDoe) errDoe++;
      wt = 1'($urandom_range(0, 1));
      memWait = wt;
      memDin = pat(w);
      stall = (wm == 2'd2) ? wt : (wm == 2'd3) ? (wt && dA && (c + 1 == sD + pD)) : 1'b0;
      if (!wr && !stall && (rm ? (dA && c + 1 == sD + pD) : (csA && c + 1 == sCs + pCs)))
        expData = pat(w);
      if (!stall) begin
        if (c == len - 1) ended = 1;
        else c++;
      end
      w++;
    end
    tagW = (wm == 2'd2) ? "R8 frozen length" : (wm == 2'd3) ? "R9 ready length" : "R3/R10 length";
    chk(doneValid && errDone == 0, tagW, 32'(doneValid), 32'(1));
    chk(errCs == 0, "R2 R4 chip-select", 32'(errCs), 0);
    chk(errRd == 0, "R2 read strobe", 32'(errRd), 0);
    chk(errWe == 0, "R7 write strobes", 32'(errWe), 0);
    chk(errBs == 0, "R7 byte selects", 32'(errBs), 0);
    chk(errDoe == 0, "R6 output enable", 32'(errDoe), 0);
    chk(rdData == expData, "R5 read data", rdData, expData);
    prevRd = expData;
    prevRead = !wr; prevOpt = fOptSaved; prevF = fSaved;
  endtask

  bit fOptSaved = 0;
  int fSaved = 0;

  task automatic go(input bit wr);
    fOptSaved = fOpt; fSaved = fCycles;
    runAccess(wr, AW'($urandom), DW'($urandom), NB'($urandom));
  endtask

  task automatic setAll(input int s, input int p, input int cy, input int r);
    for (int i = 0; i < 4; i++) begin
      tv[i] = 8'(s); tv[i+4] = 8'(p); tv[i+10] = 8'(r);
    end
    tv[8] = 8'(cy); tv[9] = 8'(cy);
    wMode = 2'd0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 14; i++) tv[i] = 8'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(memCsN && memRdN && (&memWeN) && (&memBsN), "R1 strobes idle",
        {memCsN, memRdN, 30'(memWeN)}, 32'hFFFFFFFF);
    chk(!memDoe && !doneValid && reqReady, "R1 handshake idle",
        {29'd0, memDoe, doneValid, reqReady}, 32'd1);

    // setup 0 asserts in cycle 0; read sampled on read strobe
    setAll(0, 3, 0, 0); rdMode = 1; fCycles = 0; fOpt = 0;
    go(0);
    // pulse 0 on the read strobe: no capture, data kept
    setAll(1, 0, 4, 0); tv[4] = 8'd2; rdMode = 1;
    go(0);
    // recovery stretches a short write cycle
    setAll(2, 1, 2, 0); tv[3] = 8'd1; tv[7] = 8'd2; tv[13] = 8'd4; wrMode = 1; bwMode = 0;
    go(1);
    // long float, then a write
    setAll(1, 2, 5, 0); fCycles = 4'd15; fOpt = 0; rdMode = 0;
    go(0);
    go(1);
    // float shortcut: read after read, then write
    setAll(1, 2, 5, 1); fCycles = 4'd3; fOpt = 1;
    go(0);
    go(0);
    go(1);
    // byte-write lanes
    setAll(0, 4, 6, 0); bwMode = 1; wrMode = 0;
    fOptSaved = fOpt; fSaved = fCycles;
    runAccess(1, 24'h00ABCD, 32'h11223344, 4'b0101);

    for (int n = 0; n < 80; n++) begin
      randCfg();
      go(1'($urandom_range(0, 1)));
    end
    finishRun();
  end
endmodule